// File: doc/BRIEF.md
# Timed Configuration-Byte Read Gate

This block sits beside the program-memory load path of a small CPU and lets software read the configuration fuse byte and the lock bits with an ordinary load instruction. Software writes a self-programming control register with two bits set together: a lock-read select bit and a self-program enable bit. That write opens a short, cycle-counted window. A load that executes inside the window is answered from configuration storage instead of from flash, and the pointer value decides which configuration byte comes back.

The window is one-shot. A load that is served, a store/program instruction, a rewrite of the register, or the window simply running out all drop both bits, after which loads see flash data again. While an EEPROM write is in progress, the register cannot be written and configuration reads are refused, so loads return flash data.

Top module: `cfg_read_gate`

## Requirements
- R1: With rst_n low at a rising clock edge, the control register reads 0x00 after that edge and rd_data equals flash_rdata.
- R2: A register write with ee_busy low and both bit 0 (self-program enable) and bit 3 (lock-read select) set in the write data makes ctl_q read 0x09 after the edge; all other register bits always read 0.
- R3: A register write with ee_busy low that does not set both bit 0 and bit 3 leaves ctl_q at 0x00, and cancels an open window.
- R4: A register write while ee_busy is high has no effect on ctl_q.
- R5: The edge that sets the bits is cycle 0; a load strobe in cycle 1, 2 or 3 with ptr equal to 0x0000 makes rd_data equal the fuse byte in that same cycle.
- R6: A load in the window with ptr equal to 0x0001 returns the lock bits in the low-order positions with every upper bit at 1 (0xFE for lock bits 2'b10 with two lock bits).
- R7: A load in the window with any other ptr value returns 0xFF.
- R8: A load served in the window clears both bits at that edge; later loads return flash_rdata.
- R9: When no load is served in cycles 1 to 3, ctl_q reads 0x00 from cycle 4 and a load in cycle 4 returns flash_rdata; the store deadline of 4 cycles is never outlived by an open window.
- R10: A store strobe during the window clears both bits at that edge.
- R11: A load during the window while ee_busy is high returns flash_rdata and leaves the bits set.
- R12: A second arming write inside the window restarts the count at cycle 1.
- R13: Whenever no configuration read is served, rd_data equals flash_rdata.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| ld_strobe | input | 1 | Program-memory load instruction executes this cycle |
| st_strobe | input | 1 | Store/program instruction executes this cycle |
| ptr | input | 16 | Pointer register value |
| ee_busy | input | 1 | EEPROM write in progress |
| flash_rdata | input | 8 | Byte read from flash for the current load |
| fuse_lo | input | 8 | Fuse low byte |
| lock_bits | input | 2 | Lock bits |
| rd_data | output | 8 | Byte returned to the load instruction |
| ctl_q | output | 8 | Control register contents |

## Verification
The bench builds the block with its defaults: a 16-bit pointer, two lock bits, a load window of 3 cycles and a store deadline of 4. A 3-cycle window makes both edges of the window reachable in a few cycles, so loads are placed in cycle 1, in cycle 3 (last accepted) and in cycle 4 (first refused), and a rearm is placed in cycle 3 to show the count restarting. Two lock bits leave six padding bits, so the fill with ones is visible in the returned lock byte.

// File: rtl/cfg_gate_pkg.sv
// Package: shared constants and types for the configuration read gate.
// Assumes an 8-bit control register and an 8-bit data path.
package cfg_gate_pkg;
    localparam int CTL_W   = 8;
    localparam int DATA_W  = 8;
    localparam int EN_POS  = 0;  // self-program enable bit
    localparam int SEL_POS = 3;  // lock-read select bit

    typedef enum logic [1:0] {
        SRC_FLASH = 2'd0,
        SRC_FUSE  = 2'd1,
        SRC_LOCK  = 2'd2,
        SRC_NONE  = 2'd3
    } rd_src_e;
endpackage

// File: rtl/cfg_ctl_reg.sv
// Control register holding the two enable bits.
// Does: accepts software writes unless the EEPROM is busy, decodes an arming
// write, and drops both bits when the window is consumed or runs out.
// Assumes: drop is only asserted by the window timer while armed.
module cfg_ctl_reg
    import cfg_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    input  logic             ee_busy,
    input  logic             drop,
    output logic             arm_set,
    output logic             cancel,
    output logic [CTL_W-1:0] ctl_q
);
    logic en_q;
    logic sel_q;
    logic wr_ok;

    // Decode a write that is allowed and whether it arms the window.
    always_comb begin
        wr_ok   = wr && !ee_busy;
        arm_set = wr_ok && wdata[EN_POS] && wdata[SEL_POS];
        cancel  = wr_ok && !arm_set;
    end

    // Hold the two enable bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            sel_q <= 1'b0;
        end else if (wr_ok) begin
            en_q  <= arm_set;
            sel_q <= arm_set;
        end else if (drop) begin
            en_q  <= 1'b0;
            sel_q <= 1'b0;
        end
    end

    // Present the register; unimplemented bits read as zero.
    always_comb begin
        for (int i = 0; i < CTL_W; i++) begin
            ctl_q[i] = 1'b0;
        end
        ctl_q[EN_POS]  = en_q;
        ctl_q[SEL_POS] = sel_q;
    end

    // A blocked write never sets the bits.
    assert_busy_no_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && ee_busy && !en_q) |=> !en_q);

    // A blocked write never clears the bits unless the timer drops them.
    assert_busy_no_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && ee_busy && en_q && !drop) |=> en_q);

    // Both bits always move together.
    assert_bits_paired_R2: assert property (@(posedge clk) disable iff (!rst_n)
        en_q == sel_q);
endmodule

// File: rtl/cfg_win_timer.sv
// Window timer for a configuration read.
// Does: counts cycles 1.. after an arming edge and flags expiry when the load
// deadline or the store deadline passes unmet.
// Assumes: hit and st are only meaningful while active.
module cfg_win_timer #(
    parameter int LD_WIN = 3,
    parameter int ST_WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_set,
    input  logic cancel,
    input  logic hit,
    input  logic st,
    output logic active,
    output logic consume,
    output logic expire
);
    localparam int MAXW = (LD_WIN > ST_WIN) ? LD_WIN : ST_WIN;
    localparam int CW   = $clog2(MAXW + 1);

    logic [CW-1:0] cnt_q;

    // Derive window state and the two ways it ends.
    always_comb begin
        active  = (cnt_q != '0);
        consume = active && (hit || st);
        expire  = active && (((cnt_q == CW'(LD_WIN)) && !hit) ||
                             ((cnt_q == CW'(ST_WIN)) && !st));
    end

    // Advance, restart or stop the cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (arm_set) begin
            cnt_q <= CW'(1);
        end else if (cancel || consume || expire) begin
            cnt_q <= '0;
        end else if (active) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    // The count never goes past the shorter deadline.
    assert_window_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'((LD_WIN < ST_WIN) ? LD_WIN : ST_WIN));

    // A served load closes the window.
    assert_hit_closes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (active && hit && !arm_set) |=> (cnt_q == '0));

    // A store in the window closes it.
    assert_store_closes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (active && st && !arm_set) |=> (cnt_q == '0));

    // An arming write always restarts at cycle 1.
    assert_rearm_R12: assert property (@(posedge clk) disable iff (!rst_n)
        arm_set |=> (cnt_q == CW'(1)));
endmodule

// File: rtl/cfg_rd_mux.sv
// Load data selector.
// Does: on a served configuration read, picks the fuse byte, the padded lock
// byte or all-ones by pointer value; otherwise passes the flash byte.
// Assumes: LOCK_W is between 1 and DATA_W.
module cfg_rd_mux
    import cfg_gate_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int LOCK_W = 2
) (
    input  logic              hit,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [DATA_W-1:0] flash_rdata,
    input  logic [DATA_W-1:0] fuse_lo,
    input  logic [LOCK_W-1:0] lock_bits,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] lock_byte;
    rd_src_e           src;

    // Build the lock byte with the spare upper bits at one.
    generate
        if (LOCK_W < DATA_W) begin : g_pad
            assign lock_byte = {{(DATA_W-LOCK_W){1'b1}}, lock_bits};
        end else begin : g_full
            assign lock_byte = lock_bits;
        end
    endgenerate

    // Choose the data source from the pointer.
    always_comb begin
        if (!hit)                       src = SRC_FLASH;
        else if (ptr == PTR_W'(0))      src = SRC_FUSE;
        else if (ptr == PTR_W'(1))      src = SRC_LOCK;
        else                            src = SRC_NONE;
    end

    // Drive the returned byte.
    always_comb begin
        unique case (src)
            SRC_FUSE: rd_data = fuse_lo;
            SRC_LOCK: rd_data = lock_byte;
            SRC_NONE: rd_data = '1;
            default:  rd_data = flash_rdata;
        endcase
    end
endmodule

// File: rtl/cfg_read_gate.sv
// Top of the timed configuration read gate.
// Does: ties the control register, the window timer and the load data
// selector together; a load is served only while armed and the EEPROM is idle.
// Assumes: strobes are single-cycle and synchronous to clk.
module cfg_read_gate
    import cfg_gate_pkg::*;
#(
    parameter int PTR_W  = 16,
    parameter int LOCK_W = 2,
    parameter int LD_WIN = 3,
    parameter int ST_WIN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic              ld_strobe,
    input  logic              st_strobe,
    input  logic [PTR_W-1:0]  ptr,
    input  logic              ee_busy,
    input  logic [DATA_W-1:0] flash_rdata,
    input  logic [DATA_W-1:0] fuse_lo,
    input  logic [LOCK_W-1:0] lock_bits,
    output logic [DATA_W-1:0] rd_data,
    output logic [CTL_W-1:0]  ctl_q
);
    logic arm_set;
    logic cancel;
    logic active;
    logic consume;
    logic expire;
    logic hit;
    logic drop;

    // A load is served only in an open window with the EEPROM idle.
    always_comb begin
        hit  = active && ld_strobe && !ee_busy;
        drop = consume || expire;
    end

    cfg_ctl_reg u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (ctl_wr),
        .wdata   (ctl_wdata),
        .ee_busy (ee_busy),
        .drop    (drop),
        .arm_set (arm_set),
        .cancel  (cancel),
        .ctl_q   (ctl_q)
    );

    cfg_win_timer #(
        .LD_WIN (LD_WIN),
        .ST_WIN (ST_WIN)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_set (arm_set),
        .cancel  (cancel),
        .hit     (hit),
        .st      (st_strobe),
        .active  (active),
        .consume (consume),
        .expire  (expire)
    );

    cfg_rd_mux #(
        .PTR_W  (PTR_W),
        .LOCK_W (LOCK_W)
    ) u_mux (
        .hit         (hit),
        .ptr         (ptr),
        .flash_rdata (flash_rdata),
        .fuse_lo     (fuse_lo),
        .lock_bits   (lock_bits),
        .rd_data     (rd_data)
    );

    // The register bits and the timer agree on whether a window is open.
    assert_bits_track_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q[EN_POS] == active);

    // With the bits clear, loads see flash.
    assert_flash_when_idle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_q[EN_POS] |-> (rd_data == flash_rdata));

    // While the EEPROM is busy, loads see flash.
    assert_busy_blocks_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ee_busy |-> (rd_data == flash_rdata));
endmodule

// File: tb/tb_cfg_read_gate.sv
module tb_cfg_read_gate;
    localparam int CLK_P = 10;
    localparam logic [7:0] FLASH = 8'h3C;
    localparam logic [7:0] FUSE  = 8'hA5;
    localparam logic [1:0] LOCK  = 2'b10;
    localparam logic [7:0] ARM   = 8'h09;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [7:0]  ctl_wdata = '0;
    logic        ld_strobe = 1'b0;
    logic        st_strobe = 1'b0;
    logic [15:0] ptr = '0;
    logic        ee_busy = 1'b0;
    logic [7:0]  flash_rdata = FLASH;
    logic [7:0]  fuse_lo = FUSE;
    logic [1:0]  lock_bits = LOCK;
    logic [7:0]  rd_data;
    logic [7:0]  ctl_q;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_P/2) clk = ~clk;

    cfg_read_gate dut (
        .clk (clk), .rst_n (rst_n), .ctl_wr (ctl_wr), .ctl_wdata (ctl_wdata),
        .ld_strobe (ld_strobe), .st_strobe (st_strobe), .ptr (ptr),
        .ee_busy (ee_busy), .flash_rdata (flash_rdata), .fuse_lo (fuse_lo),
        .lock_bits (lock_bits), .rd_data (rd_data), .ctl_q (ctl_q)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Advance to the next negedge (next cycle), clearing strobes.
    task automatic next_cyc();
        @(negedge clk);
        ctl_wr = 1'b0; ld_strobe = 1'b0; st_strobe = 1'b0;
        #1;
    endtask

    // Write the register this cycle; return in the following cycle.
    task automatic wr_reg(input logic [7:0] d);
        ctl_wr = 1'b1; ctl_wdata = d;
        next_cyc();
    endtask

    task automatic load(input logic [15:0] p);
        ld_strobe = 1'b1; ptr = p; #1;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        next_cyc(); next_cyc();
        chk("R1 ctl after reset", ctl_q, 8'h00);
        chk("R1 rd_data after reset", rd_data, FLASH);
        rst_n = 1'b1;
        next_cyc();
    endtask

    task automatic t_fuse_read();
        wr_reg(ARM);                     // now cycle 1
        chk("R2 armed", ctl_q, ARM);
        load(16'h0000);
        chk("R5 fuse in cycle 1", rd_data, FUSE);
        next_cyc();
        chk("R8 bits cleared after read", ctl_q, 8'h00);
        load(16'h0000);
        chk("R8 later load sees flash", rd_data, FLASH);
        next_cyc();
    endtask

    task automatic t_lock_last_cycle();
        wr_reg(ARM);                     // cycle 1
        next_cyc();                      // cycle 2
        next_cyc();                      // cycle 3
        chk("R9 still armed in cycle 3", ctl_q, ARM);
        load(16'h0001);
        chk("R6 lock byte in cycle 3", rd_data, 8'hFE);
        next_cyc();
        chk("R8 cleared after lock read", ctl_q, 8'h00);
    endtask

    task automatic t_other_ptr();
        wr_reg(ARM);
        next_cyc();                      // cycle 2
        load(16'h0100);
        chk("R7 other pointer", rd_data, 8'hFF);
        next_cyc();
        chk("R7 other pointer clears bits", ctl_q, 8'h00);
    endtask

    task automatic t_timeout();
        wr_reg(ARM);
        next_cyc(); next_cyc(); next_cyc();  // cycle 4
        chk("R9 expired in cycle 4", ctl_q, 8'h00);
        load(16'h0000);
        chk("R9 cycle 4 load sees flash", rd_data, FLASH);
        next_cyc();
    endtask

    task automatic t_store();
        wr_reg(ARM);
        st_strobe = 1'b1;
        next_cyc();
        chk("R10 store clears bits", ctl_q, 8'h00);
        load(16'h0000);
        chk("R10 load after store sees flash", rd_data, FLASH);
        next_cyc();
    endtask

    task automatic t_busy_write();
        ee_busy = 1'b1;
        wr_reg(ARM);
        chk("R4 busy write does not arm", ctl_q, 8'h00);
        ee_busy = 1'b0;
        wr_reg(ARM);                     // cycle 1
        ee_busy = 1'b1;
        wr_reg(8'h00);                   // cycle 2
        chk("R4 busy write does not clear", ctl_q, ARM);
        ee_busy = 1'b0;
        next_cyc(); next_cyc();
    endtask

    task automatic t_busy_read();
        wr_reg(ARM);                     // cycle 1
        ee_busy = 1'b1;
        load(16'h0000);
        chk("R11 busy load sees flash", rd_data, FLASH);
        next_cyc();                      // cycle 2
        ee_busy = 1'b0;
        chk("R11 bits kept after busy load", ctl_q, ARM);
        load(16'h0000);
        chk("R11 served after busy ends", rd_data, FUSE);
        next_cyc();
    endtask

    task automatic t_partial();
        wr_reg(8'h01);
        chk("R3 enable bit alone", ctl_q, 8'h00);
        wr_reg(8'h08);
        chk("R3 select bit alone", ctl_q, 8'h00);
        wr_reg(8'hFF);
        chk("R2 other bits read zero", ctl_q, ARM);
        wr_reg(8'h01);
        chk("R3 write cancels window", ctl_q, 8'h00);
        load(16'h0000);
        chk("R3 cancelled window sees flash", rd_data, FLASH);
        next_cyc();
    endtask

    task automatic t_rearm();
        wr_reg(ARM);                     // cycle 1
        next_cyc();                      // cycle 2
        next_cyc();                      // cycle 3
        wr_reg(ARM);                     // new cycle 1
        next_cyc();                      // new cycle 2
        next_cyc();                      // new cycle 3
        chk("R12 still armed after restart", ctl_q, ARM);
        load(16'h0000);
        chk("R12 load in restarted window", rd_data, FUSE);
        next_cyc();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        chk("R13 idle passes flash", rd_data, FLASH);
        t_fuse_read();
        t_lock_last_cycle();
        t_other_ptr();
        t_timeout();
        t_store();
        t_busy_write();
        t_busy_read();
        t_partial();
        t_rearm();
        flash_rdata = 8'h5A; #1;
        chk("R13 flash follows input", rd_data, 8'h5A);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule